// File: doc/BRIEF.md
# Supply-Supervised Watchdog Reset Generator

This block turns three supply comparator flags and a software heartbeat into a pair of complementary reset outputs for a logic system. It follows the supply with hysteresis. A dip to the lower threshold, or a loss of the minimum operating level, forces reset at once. Once the supply has climbed back to the upper threshold, reset is held for a long power-on interval. After that the block watches the heartbeat input `wd_ck`.

The watchdog does not use a reload counter. It uses an up/down ramp that stands in for a timing capacitor. After release the ramp falls from full toward empty. Each falling edge of `wd_ck`, seen while the ramp is falling, turns it around so that it charges back to full. If the ramp ever reaches empty, reset is asserted and the ramp recharges to full. Reset is then released and monitoring resumes. Because the heartbeat may stop at any ramp level, the time from the last edge to the watchdog reset lies between the discharge time and the discharge time plus the charge time. The three intervals are set by parameters and default to the ratio 1000:100:20.

Top module: `supwd_rst_gen`

## Requirements
- R1: `rst_o` and `rst_n_o` are complementary in every cycle. `rst_o` is active high and `rst_n_o` is active low.
- R2: While the synchronous reset `rst` is high, reset is asserted (`rst_o`=1, `rst_n_o`=0), and the block comes out of it in the supply-off state.
- R3: When `sup_lo`=1 (supply at or below the lower threshold) or `sup_min`=0 (supply below the minimum operating level), `rst_o` is 1 in that same cycle. The ramp is emptied and the power-on sequence restarts.
- R4: The supply monitor has hysteresis. From the supply-off state, reset is left only after `sup_hi`=1 is seen, so a supply between the thresholds (`sup_hi`=0, `sup_lo`=0) keeps reset asserted. Once reset has been released, `sup_hi` falling to 0 while `sup_lo` stays 0 does not assert reset.
- R5: The power-on hold lasts exactly TPR_CYC cycles. It is counted from the first rising clock edge that samples `sup_hi`=1 with a good supply. After the hold, reset is released.
- R6: `wd_ck` activity during the power-on hold has no effect on its length.
- R7: While falling edges of `wd_ck` arrive at intervals of at most TWD_CYC cycles, `rst_o` stays 0.
- R8: When `wd_ck` stops after a falling edge, `rst_o` rises between TWD_CYC and TWD_CYC+TWR_CYC+4 cycles after that edge. The +4 covers the two-flop synchroniser and edge detection.
- R9: A watchdog reset lasts exactly TWR_CYC cycles. Monitoring then resumes with a full ramp, so a resumed heartbeat keeps reset released.
- R10: Only falling edges of `wd_ck` restart the ramp. A rising edge after the last falling edge does not delay the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the model |
| sup_hi | input | 1 | Supply at or above the upper threshold |
| sup_lo | input | 1 | Supply at or below the lower threshold |
| sup_min | input | 1 | Supply above the minimum operating level |
| wd_ck | input | 1 | Monitored heartbeat; falling edges count |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low, the complement of `rst_o` |

## Verification
The hardest behaviour to reach from the ports is the spread of the timeout window. How long the timeout takes depends on the ramp level at the moment the last heartbeat edge is detected, and that level cannot be seen directly. The bench therefore first runs a regular heartbeat so that the ramp sits at a known phase of its fall. It then stops the heartbeat and checks the count against both bounds. A second run adds a rising edge 50 cycles after the final fall. That rising edge would push the timeout beyond the upper bound if it were wrongly treated as a heartbeat. The power-on hold is measured while `wd_ck` toggles throughout, to show that the hold ignores it.

// File: rtl/supwd_pkg.sv
package supwd_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_DIS,
        ST_CHG,
        ST_WDR
    } supwd_st_e;

    typedef enum logic [2:0] {
        RAMP_KEEP,
        RAMP_CLR,
        RAMP_FULL,
        RAMP_UP,
        RAMP_DOWN
    } ramp_cmd_e;

    typedef struct packed {
        supwd_st_e st;
    } supwd_ctrl_s;

endpackage

// File: rtl/supwd_ck_edge.sv
module supwd_ck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ck_i,
    output logic fall_o
);
    // synchroniser stages plus one history flop for edge detection
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], ck_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/supwd_hold_timer.sv
module supwd_hold_timer #(
    parameter int COUNT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT + 1) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? cnt_q + CW'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == CW'(COUNT - 1));
endmodule

// File: rtl/supwd_ramp.sv
module supwd_ramp
    import supwd_pkg::*;
#(
    parameter int SPAN    = 2000,
    parameter int UP_STEP = 100,
    parameter int DN_STEP = 20,
    parameter int LW      = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  ramp_cmd_e     cmd_i,
    output logic [LW-1:0] lvl_o,
    output logic          near_top_o,
    output logic          near_bot_o
);
    logic [LW-1:0] lvl_d, lvl_q;

    // one more step up reaches full; one more step down reaches empty
    assign near_top_o = lvl_q >= LW'(SPAN - UP_STEP);
    assign near_bot_o = lvl_q <= LW'(DN_STEP);

    always_comb begin
        lvl_d = lvl_q;
        case (cmd_i)
            RAMP_CLR:  lvl_d = '0;
            RAMP_FULL: lvl_d = LW'(SPAN);
            RAMP_UP:   lvl_d = near_top_o ? LW'(SPAN) : lvl_q + LW'(UP_STEP);
            RAMP_DOWN: lvl_d = near_bot_o ? '0 : lvl_q - LW'(DN_STEP);
            default:   lvl_d = lvl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_d;
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/supwd_rst_gen.sv
module supwd_rst_gen
    import supwd_pkg::*;
#(
    parameter int TWR_CYC     = 20,
    parameter int TWD_CYC     = 100,
    parameter int TPR_CYC     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_hi,
    input  logic sup_lo,
    input  logic sup_min,
    input  logic wd_ck,
    output logic rst_o,
    output logic rst_n_o
);
    // ramp spans TWR*TWD units: rising steps of TWD take TWR cycles,
    // falling steps of TWR take TWD cycles
    localparam int SPAN    = TWR_CYC * TWD_CYC;
    localparam int LVL_W   = $clog2(SPAN + 1);
    localparam int UP_STEP = TWD_CYC;
    localparam int DN_STEP = TWR_CYC;

    supwd_ctrl_s ctrl_d, ctrl_q;
    ramp_cmd_e   ramp_cmd;
    logic        hold_run, hold_done;
    logic        ck_fall, near_top, near_bot;
    logic        supply_bad, in_rst;
    logic [LVL_W-1:0] ramp_lvl;

    supwd_ck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .ck_i   (wd_ck),
        .fall_o (ck_fall)
    );

    supwd_hold_timer #(.COUNT(TPR_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    supwd_ramp #(
        .SPAN    (SPAN),
        .UP_STEP (UP_STEP),
        .DN_STEP (DN_STEP),
        .LW      (LVL_W)
    ) u_ramp (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (ramp_cmd),
        .lvl_o      (ramp_lvl),
        .near_top_o (near_top),
        .near_bot_o (near_bot)
    );

    assign supply_bad = sup_lo || !sup_min;

    always_comb begin
        ctrl_d   = ctrl_q;
        ramp_cmd = RAMP_KEEP;
        hold_run = 1'b0;
        if (supply_bad) begin
            ctrl_d.st = ST_OFF;
            ramp_cmd  = RAMP_CLR;
        end else begin
            case (ctrl_q.st)
                ST_OFF: begin
                    ramp_cmd = RAMP_CLR;
                    if (sup_hi) ctrl_d.st = ST_HOLD;
                end
                ST_HOLD: begin
                    hold_run = 1'b1;
                    if (hold_done) begin
                        ctrl_d.st = ST_DIS;
                        ramp_cmd  = RAMP_FULL;
                    end
                end
                ST_DIS: begin
                    if (ck_fall) begin
                        ctrl_d.st = ST_CHG;
                    end else begin
                        ramp_cmd = RAMP_DOWN;
                        if (near_bot) ctrl_d.st = ST_WDR;
                    end
                end
                ST_CHG, ST_WDR: begin
                    ramp_cmd = RAMP_UP;
                    if (near_top) ctrl_d.st = ST_DIS;
                end
                default: ctrl_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q.st <= ST_OFF;
        else     ctrl_q    <= ctrl_d;
    end

    assign in_rst  = supply_bad || !((ctrl_q.st == ST_DIS) || (ctrl_q.st == ST_CHG));
    assign rst_o   = in_rst;
    assign rst_n_o = !in_rst;
endmodule

// File: rtl/supwd_rst_gen_chk.sv
module supwd_rst_gen_chk #(
    parameter int TWR_CYC = 20,
    parameter int TWD_CYC = 100,
    parameter int TPR_CYC = 1000,
    parameter int LVL_W   = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             sup_lo,
    input logic             sup_min,
    input logic             rst_o,
    input logic             rst_n_o,
    input logic [LVL_W-1:0] lvl
);
    localparam int SPAN = TWR_CYC * TWD_CYC;

    int hi_len_q, lo_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len_q <= 0;
            lo_len_q <= 0;
        end else begin
            hi_len_q <= rst_o  ? ((hi_len_q < TPR_CYC) ? hi_len_q + 1 : hi_len_q) : 0;
            lo_len_q <= !rst_o ? ((lo_len_q < TWD_CYC) ? lo_len_q + 1 : lo_len_q) : 0;
        end
    end

    // R1
    cmpl_out_chk: assert property (@(posedge clk) disable iff (rst)
        rst_o != rst_n_o);

    // R3
    sup_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sup_lo || !sup_min) |-> rst_o);

    // R5 R9
    release_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> (hi_len_q == TWR_CYC || hi_len_q >= TPR_CYC));

    // R8
    timeout_min_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_o) && sup_min && !sup_lo) |-> (lo_len_q >= TWD_CYC));

    // R9
    ramp_range_chk: assert property (@(posedge clk) disable iff (rst)
        lvl <= LVL_W'(SPAN));
endmodule

bind supwd_rst_gen supwd_rst_gen_chk #(
    .TWR_CYC (TWR_CYC),
    .TWD_CYC (TWD_CYC),
    .TPR_CYC (TPR_CYC),
    .LVL_W   (LVL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sup_lo  (sup_lo),
    .sup_min (sup_min),
    .rst_o   (rst_o),
    .rst_n_o (rst_n_o),
    .lvl     (ramp_lvl)
);

// File: tb/supwd_rst_gen_tb.sv
`timescale 1ns/1ps
module supwd_rst_gen_tb;
    localparam int TWR = 20;
    localparam int TWD = 100;
    localparam int TPR = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_hi = 1'b0;
    logic sup_lo = 1'b1;
    logic sup_min = 1'b0;
    logic wd_ck = 1'b1;
    logic rst_o, rst_n_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    supwd_rst_gen #(
        .TWR_CYC (TWR),
        .TWD_CYC (TWD),
        .TPR_CYC (TPR),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .sup_hi  (sup_hi),
        .sup_lo  (sup_lo),
        .sup_min (sup_min),
        .wd_ck   (wd_ck),
        .rst_o   (rst_o),
        .rst_n_o (rst_n_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(string req, int act, int lo, int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic outs(string req, int exp_rst);
        chk(req, int'(rst_o), exp_rst);
        chk("R1", int'(rst_n_o), 1 - exp_rst);
    endtask

    // R2 R4: reset state, then supply between thresholds keeps reset
    task automatic t_reset();
        repeat (3) @(negedge clk);
        outs("R2", 1);
        rst = 1'b0;
        sup_min = 1'b1;
        sup_lo = 1'b0;
        sup_hi = 1'b0;
        repeat (50) @(negedge clk);
        outs("R4", 1);
    endtask

    // R5 (and R6 when toggling): hold width counted in reset samples
    task automatic t_power_on(string req, bit toggle);
        int cnt = 0;
        sup_hi = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst_o || cnt > 5000) break;
            cnt++;
            if (toggle && (cnt % 5 == 0)) wd_ck = ~wd_ck;
        end
        chk(req, cnt, TPR);
        wd_ck = 1'b1;
    endtask

    // R7: regular heartbeat keeps reset released
    task automatic t_keep_alive(string req, int periods, int half);
        int bad = 0;
        for (int p = 0; p < periods; p++) begin
            wd_ck = 1'b0;
            repeat (half) begin
                @(negedge clk);
                if (rst_o) bad++;
            end
            wd_ck = 1'b1;
            repeat (half) begin
                @(negedge clk);
                if (rst_o) bad++;
            end
        end
        chk(req, bad, 0);
        outs("R1", 0);
    endtask

    // R8 R9 (R10 when rise_at > 0): stop heartbeat after a falling edge
    task automatic t_timeout(string req, int rise_at);
        int n = 0;
        int w = 1;
        wd_ck = 1'b0;
        forever begin
            @(negedge clk);
            n++;
            if (rise_at > 0 && n == rise_at) wd_ck = 1'b1;
            if (rst_o || n > 1000) break;
        end
        chk_rng(req, n, TWD, TWD + TWR + 4);
        forever begin
            @(negedge clk);
            if (!rst_o || w > 1000) break;
            w++;
        end
        chk("R9", w, TWR);
        wd_ck = 1'b1;
        @(negedge clk);
        t_keep_alive("R9", 6, 30);
    endtask

    // R3 R4 R5: hysteresis and supply dips
    task automatic t_supply();
        int bad = 0;
        sup_hi = 1'b0;
        t_keep_alive("R4", 5, 30);
        sup_lo = 1'b1;
        #1;
        outs("R3", 1);
        repeat (20) @(negedge clk);
        sup_lo = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!rst_o) bad++;
            if (i % 9 == 0) wd_ck = ~wd_ck;
        end
        chk("R4", bad, 0);
        wd_ck = 1'b1;
        t_power_on("R5", 1'b0);
        t_keep_alive("R7", 4, 30);
        sup_min = 1'b0;
        #1;
        outs("R3", 1);
        repeat (10) @(negedge clk);
        outs("R3", 1);
        sup_min = 1'b1;
        t_power_on("R5", 1'b0);
        t_keep_alive("R7", 4, 30);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_power_on("R6", 1'b1);
        t_keep_alive("R7", 20, 30);
        t_keep_alive("R7", 5, 50);
        t_timeout("R8", 0);
        t_timeout("R10", 50);
        t_supply();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule